// File: doc/BRIEF.md
# SPI Host Request Receiver

This block is the receive half of an SPI target link (mode 0: data sampled on the rising clock edge, MSB first) that carries host command requests. While chip select is low, it shifts in bytes, stores them in a receive FIFO and counts them. A fixed-size request header carries a protocol version byte, a reserved byte and a 16-bit payload length. The block captures these fields as they go by and decides in hardware when the whole request has arrived.

After a set number of bytes it judges the header. A good header leads to a one-cycle `request_valid` pulse once the expected total has been received, and the block then ignores further traffic. A bad header moves it to a bad-data state. Software reads the stored bytes through a valid/ready byte port. Raising chip select ends the transaction: the FIFO, the count and the status return to their idle values.

Top module: `spi_rq_rx`

## Requirements
- R1: After reset, `rx_state` is 0 (ready), `status` is 0, `rd_valid` is 0 and `request_valid` is 0.
- R2: A falling edge of `spi_cs_n` while ready moves `rx_state` to 1 (receiving).
- R3: Bits on `spi_mosi` are sampled on rising `spi_sclk`, MSB first. Every 8 bits form one byte, and stored bytes leave `rd_data` in arrival order, one per cycle in which `rd_valid` and `rd_ready` are both high.
- R4: The header is judged once 12 bytes (8 header bytes plus 4 bytes of slack) are stored. The byte at offset 0 must equal 3, the byte at offset 5 must be 0, and the payload length is little-endian at offsets 6 (low) and 7 (high). The expected total is 8 plus the length and appears on `req_len`. When the count reaches the larger of 12 and the total, `request_valid` is high for exactly one cycle, `rx_state` becomes 2 (processing) and `status` bit 0 is set.
- R5: A version byte other than 3 moves `rx_state` to 3 (bad), sets `status` bit 1 and gives no `request_valid`.
- R6: A nonzero reserved byte (offset 5) is treated as bad in the same way.
- R7: An expected total above the FIFO depth (32) is treated as bad in the same way.
- R8: Bytes that arrive while processing are neither stored nor counted.
- R9: Once the FIFO holds 32 bytes, further bytes are dropped and stored bytes are never overwritten. In the bad state, bytes keep being stored until the FIFO is full.
- R10: A rising edge of `spi_cs_n` returns `rx_state` to 0, clears `status` and empties the FIFO.
- R11: Writing a 1 to a bit of `status_clr` clears the matching `status` bit. A 0 leaves that bit unchanged.
- R12: A request whose total is below 12 still needs 12 bytes. `request_valid` does not fire before the twelfth byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from the host |
| rd_data | output | 8 | Oldest stored byte |
| rd_valid | output | 1 | FIFO holds at least one byte |
| rd_ready | input | 1 | Consumer takes `rd_data` this cycle |
| request_valid | output | 1 | One-cycle pulse: complete good request |
| req_len | output | 17 | Expected total request length in bytes |
| rx_state | output | 2 | 0 ready, 1 receiving, 2 processing, 3 bad |
| status | output | 2 | Bit 0 request done, bit 1 bad data |
| status_clr | input | 2 | Write-one-to-clear strobes for `status` |

## Verification
The hardest condition to reach is a full FIFO. A good header ends reception before the buffer can fill, so overflow can only happen after a rejected header. The bench therefore sends a header whose length makes the total exceed the depth, holds `rd_ready` low and keeps clocking in bytes past 32. It then drains the FIFO and checks that only the first 32 bytes come out, in order. Chip-select flush and discard during processing are checked by draining the port and confirming that no unexpected byte appears.

// File: rtl/spi_rq_pkg.sv
package spi_rq_pkg;
   typedef enum logic [1:0] {
      ST_READY = 2'd0,
      ST_RECV  = 2'd1,
      ST_PROC  = 2'd2,
      ST_BAD   = 2'd3
   } rq_state_e;

   localparam int HDR_BYTES = 8;
   localparam int HDR_SLACK = 4;
   localparam int VER_OFS   = 0;
   localparam int RSV_OFS   = 5;
   localparam logic [7:0] PROTO_VER = 8'd3;
endpackage

// File: rtl/spi_rq_front.sv
module spi_rq_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sclk,
   input  logic       cs_n,
   input  logic       mosi,
   output logic       byte_stb,
   output logic [7:0] byte_data,
   output logic       cs_fall,
   output logic       cs_rise
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sclk_q, cs_q, mosi_q;
   logic sclk_d, cs_d;
   logic [2:0] bit_cnt;
   logic [6:0] shreg;

   wire sclk_s = sclk_q[SYNC_STAGES-1];
   wire cs_s   = cs_q[SYNC_STAGES-1];
   wire mosi_s = mosi_q[SYNC_STAGES-1];
   wire sclk_rise = sclk_s & ~sclk_d;

   assign cs_fall = cs_d & ~cs_s;
   assign cs_rise = ~cs_d & cs_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= '0;
         cs_q   <= '1;
         mosi_q <= '0;
         sclk_d <= 1'b0;
         cs_d   <= 1'b1;
      end else begin
         sclk_q <= {sclk_q[SYNC_STAGES-2:0], sclk};
         cs_q   <= {cs_q[SYNC_STAGES-2:0], cs_n};
         mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi};
         sclk_d <= sclk_s;
         cs_d   <= cs_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         shreg     <= '0;
         byte_stb  <= 1'b0;
         byte_data <= '0;
      end else begin
         byte_stb <= 1'b0;
         if (cs_s) begin
            bit_cnt <= '0;
         end else if (sclk_rise) begin
            shreg   <= {shreg[5:0], mosi_s};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
               byte_stb  <= 1'b1;
               byte_data <= {shreg, mosi_s};
            end
         end
      end
   end
endmodule

// File: rtl/spi_rq_fifo.sv
module spi_rq_fifo #(
   parameter int DEPTH = 32,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [7:0]    push_data,
   input  logic          pop,
   output logic [7:0]    rd_data,
   output logic          rd_valid,
   output logic          full,
   output logic [LW-1:0] level
);
   logic [7:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;

   assign full     = (level == LW'(DEPTH));
   assign rd_valid = (level != '0);
   assign rd_data  = mem[rd_ptr];

   wire do_push = push & ~full;
   wire do_pop  = pop & rd_valid;

   function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= nxt(wr_ptr);
         if (do_pop)  rd_ptr <= nxt(rd_ptr);
         level <= level + LW'(do_push) - LW'(do_pop);
      end
   end
endmodule

// File: rtl/spi_rq_hdr.sv
module spi_rq_hdr
   import spi_rq_pkg::*;
#(
   parameter int DEPTH       = 32,
   parameter int LEN_OFS     = 6,
   parameter bit LEN_BIG_END = 1'b0,
   parameter int IW          = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          stb,
   input  logic [IW-1:0] idx,
   input  logic [7:0]    data,
   output logic [16:0]   total,
   output logic          bad
);
   logic [7:0] ver_q, rsv_q, len_a, len_b;
   logic [15:0] field;

   if (LEN_BIG_END) begin : g_be
      assign field = {len_a, len_b};
   end else begin : g_le
      assign field = {len_b, len_a};
   end

   assign total = 17'(HDR_BYTES) + {1'b0, field};
   assign bad   = (ver_q != PROTO_VER) || (rsv_q != 8'd0) ||
                  (total == 17'd0) || (total > 17'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ver_q <= '0; rsv_q <= '0; len_a <= '0; len_b <= '0;
      end else if (clear) begin
         ver_q <= '0; rsv_q <= '0; len_a <= '0; len_b <= '0;
      end else if (stb) begin
         if (idx == IW'(VER_OFS))     ver_q <= data;
         if (idx == IW'(RSV_OFS))     rsv_q <= data;
         if (idx == IW'(LEN_OFS))     len_a <= data;
         if (idx == IW'(LEN_OFS + 1)) len_b <= data;
      end
   end
endmodule

// File: rtl/spi_rq_rx.sv
module spi_rq_rx
   import spi_rq_pkg::*;
#(
   parameter int DEPTH       = 32,
   parameter int LEN_OFS     = 6,
   parameter bit LEN_BIG_END = 1'b0,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        spi_sclk,
   input  logic        spi_cs_n,
   input  logic        spi_mosi,
   output logic [7:0]  rd_data,
   output logic        rd_valid,
   input  logic        rd_ready,
   output logic        request_valid,
   output logic [16:0] req_len,
   output logic [1:0]  rx_state,
   output logic [1:0]  status,
   input  logic [1:0]  status_clr
);
   localparam int CW      = $clog2(DEPTH + 1);
   localparam int HDR_CHK = HDR_BYTES + HDR_SLACK;

   if (DEPTH < HDR_CHK) begin : g_bad_depth
      $error("DEPTH must hold the header plus slack");
   end
   if (LEN_OFS < 0 || LEN_OFS + 1 >= HDR_BYTES) begin : g_bad_ofs
      $error("LEN_OFS must place the length field inside the header");
   end

   rq_state_e state;
   logic byte_stb, cs_fall, cs_rise, fifo_full, hdr_bad;
   logic [7:0] byte_data;
   logic [CW-1:0] cnt;
   logic [CW-1:0] fifo_level;
   logic [16:0] total;

   wire accept = byte_stb && (state == ST_RECV || state == ST_BAD) && !fifo_full;
   wire hdr_avail = (cnt >= CW'(HDR_CHK));

   spi_rq_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
      .byte_stb(byte_stb), .byte_data(byte_data), .cs_fall(cs_fall), .cs_rise(cs_rise)
   );

   spi_rq_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(cs_rise), .push(accept), .push_data(byte_data),
      .pop(rd_ready), .rd_data(rd_data), .rd_valid(rd_valid), .full(fifo_full),
      .level(fifo_level)
   );

   spi_rq_hdr #(.DEPTH(DEPTH), .LEN_OFS(LEN_OFS), .LEN_BIG_END(LEN_BIG_END), .IW(CW)) u_hdr (
      .clk(clk), .rst_n(rst_n), .clear(cs_rise), .stb(accept), .idx(cnt),
      .data(byte_data), .total(total), .bad(hdr_bad)
   );

   assign req_len  = total;
   assign rx_state = state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= ST_READY;
         cnt           <= '0;
         request_valid <= 1'b0;
         status        <= '0;
      end else begin
         request_valid <= 1'b0;
         status        <= status & ~status_clr;
         if (accept) cnt <= cnt + CW'(1);
         if (cs_rise) begin
            state  <= ST_READY;
            cnt    <= '0;
            status <= '0;
         end else begin
            unique case (state)
               ST_READY: if (cs_fall) state <= ST_RECV;
               ST_RECV: begin
                  if (hdr_avail) begin
                     if (hdr_bad) begin
                        state     <= ST_BAD;
                        status[1] <= 1'b1;
                     end else if (17'(cnt) >= total) begin
                        state         <= ST_PROC;
                        request_valid <= 1'b1;
                        status[0]     <= 1'b1;
                     end
                  end
               end
               ST_PROC, ST_BAD: ;
               default: state <= ST_READY;
            endcase
         end
      end
   end
endmodule

// File: rtl/spi_rq_rx_chk.sv
module spi_rq_rx_chk #(
   parameter int DEPTH = 32,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          request_valid,
   input logic [1:0]    rx_state,
   input logic [1:0]    status,
   input logic          cs_rise,
   input logic [CW-1:0] fifo_level,
   input logic          rd_valid,
   input logic          rd_ready
);
   wire popping = rd_valid & rd_ready;

   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      request_valid |=> !request_valid);

   a_r4_pulse_in_proc: assert property (@(posedge clk) disable iff (!rst_n)
      request_valid |-> (rx_state == 2'd2 && status[0]));

   a_r5_bad_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_state == 2'd3) |-> !request_valid);

   a_r8_proc_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_state == 2'd2 && !cs_rise && !popping) |=> fifo_level == $past(fifo_level));

   a_r9_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_level == CW'(DEPTH) && !cs_rise && !popping) |=> fifo_level == CW'(DEPTH));

   a_r10_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> (rx_state == 2'd0 && status == 2'd0 && fifo_level == '0));
endmodule

bind spi_rq_rx spi_rq_rx_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .request_valid(request_valid), .rx_state(rx_state),
   .status(status), .cs_rise(cs_rise), .fifo_level(fifo_level),
   .rd_valid(rd_valid), .rd_ready(rd_ready)
);

// File: tb/spi_rq_rx_tb.sv
module spi_rq_rx_tb;
   localparam int HALF = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic rd_ready = 1'b0;
   logic [1:0] status_clr = 2'b00;
   logic [7:0] rd_data;
   logic rd_valid, request_valid;
   logic [16:0] req_len;
   logic [1:0] rx_state, status;

   int compared = 0, mismatched = 0, vcnt = 0;
   bit done = 0;
   logic [7:0] expq[$];

   always #2.5 clk = ~clk;

   spi_rq_rx u_dut (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
      .request_valid(request_valid), .req_len(req_len), .rx_state(rx_state),
      .status(status), .status_clr(status_clr)
   );

   // monitor: scoreboard pop and pulse counting, away from the active edge
   always @(negedge clk) begin
      if (request_valid) vcnt++;
      if (rst_n && rd_valid && rd_ready) begin
         compared++;
         if (expq.size() == 0) begin
            mismatched++;
            $display("FAIL R3/R8: unexpected byte act=%02h exp=<none>", rd_data);
         end else begin
            logic [7:0] e;
            e = expq.pop_front();
            if (rd_data !== e) begin
               mismatched++;
               $display("FAIL R3: byte act=%02h exp=%02h", rd_data, e);
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic check(input string tag, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input bit stored);
      for (int i = 7; i >= 0; i--) begin
         mosi = b[i];
         tick(HALF);
         sclk = 1'b1;
         tick(HALF);
         sclk = 1'b0;
      end
      if (stored) expq.push_back(b);
   endtask

   task automatic cs_begin();
      cs_n = 1'b0;
      tick(6);
   endtask

   task automatic cs_end();
      tick(4);
      cs_n = 1'b1;
      expq.delete();
      tick(8);
   endtask

   task automatic send_hdr(input logic [7:0] ver, input logic [7:0] rsv, input logic [15:0] len);
      send_byte(ver, 1); send_byte(8'hA5, 1); send_byte(8'h34, 1); send_byte(8'h12, 1);
      send_byte(8'h01, 1); send_byte(rsv, 1); send_byte(len[7:0], 1); send_byte(len[15:8], 1);
   endtask

   task automatic drain();
      rd_ready = 1'b1;
      tick(3 * 40);
      rd_ready = 1'b0;
      tick(2);
      check("R3 queue drained", expq.size(), 0);
      check("R3 rd_valid after drain", int'(rd_valid), 0);
   endtask

   initial begin
      int v0;
      tick(4);
      rst_n = 1'b1;
      tick(2);
      // R1 reset state
      check("R1 rx_state", rx_state, 0);
      check("R1 status", status, 0);
      check("R1 rd_valid", int'(rd_valid), 0);
      check("R1 request_valid", int'(request_valid), 0);

      // normal request, len 6 -> total 14
      cs_begin();
      check("R2 receiving", rx_state, 1);
      v0 = vcnt;
      send_hdr(8'd3, 8'd0, 16'd6);
      for (int i = 0; i < 4; i++) send_byte(8'h50 + 8'(i), 1);
      tick(6);
      check("R4 no pulse at 12 bytes", vcnt - v0, 0);
      check("R4 req_len", int'(req_len), 14);
      send_byte(8'h60, 1); send_byte(8'h61, 1);
      tick(6);
      check("R4 one pulse", vcnt - v0, 1);
      check("R4 processing", rx_state, 2);
      check("R4 status done", status, 1);
      send_byte(8'hEE, 0); send_byte(8'hEF, 0); send_byte(8'hF0, 0);
      tick(6);
      check("R8 still one pulse", vcnt - v0, 1);
      drain();
      status_clr = 2'b10; tick(1); status_clr = 2'b00; tick(1);
      check("R11 zero leaves bit", status, 1);
      status_clr = 2'b01; tick(1); status_clr = 2'b00; tick(1);
      check("R11 write one clears", status, 0);
      cs_end();
      check("R10 ready after end", rx_state, 0);

      // short request, len 0 -> needs 12 bytes
      cs_begin();
      v0 = vcnt;
      send_hdr(8'd3, 8'd0, 16'd0);
      tick(6);
      check("R12 no pulse at 8 bytes", vcnt - v0, 0);
      check("R12 still receiving", rx_state, 1);
      for (int i = 0; i < 4; i++) send_byte(8'hC0 + 8'(i), 1);
      tick(6);
      check("R12 pulse at 12 bytes", vcnt - v0, 1);
      drain();
      cs_end();

      // bad version
      cs_begin();
      v0 = vcnt;
      send_hdr(8'd2, 8'd0, 16'd2);
      for (int i = 0; i < 4; i++) send_byte(8'h70 + 8'(i), 1);
      tick(6);
      check("R5 bad state", rx_state, 3);
      check("R5 bad status", status, 2);
      check("R5 no pulse", vcnt - v0, 0);
      cs_end();
      check("R10 status cleared", status, 0);
      check("R10 state ready", rx_state, 0);

      // reserved byte nonzero
      cs_begin();
      v0 = vcnt;
      send_hdr(8'd3, 8'h01, 16'd2);
      for (int i = 0; i < 4; i++) send_byte(8'h80 + 8'(i), 1);
      tick(6);
      check("R6 bad state", rx_state, 3);
      check("R6 no pulse", vcnt - v0, 0);
      cs_end();

      // oversize total 38 > 32, then overflow
      cs_begin();
      v0 = vcnt;
      send_hdr(8'd3, 8'd0, 16'd30);
      for (int i = 0; i < 4; i++) send_byte(8'h90 + 8'(i), 1);
      tick(6);
      check("R7 bad state", rx_state, 3);
      check("R7 bad status", status, 2);
      for (int i = 12; i < 40; i++) send_byte(8'(i), (i < 32));
      tick(6);
      check("R9 no pulse", vcnt - v0, 0);
      drain();
      cs_end();

      // flush by chip-select rise
      cs_begin();
      for (int i = 0; i < 5; i++) send_byte(8'hB0 + 8'(i), 1);
      tick(6);
      check("R3 bytes held", int'(rd_valid), 1);
      cs_end();
      check("R10 fifo emptied", int'(rd_valid), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      done = 1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: act=timeout exp=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule